// File: doc/BRIEF.md
# Opcode-Fetch Strobe Controller with Return-Opcode Replay

This block sits between a CPU fetch sequencer and an external memory bus. It runs each bus read as a three-state machine cycle and decides whether the opcode-fetch strobe `m1_n` is driven low. Two control bits govern that choice: a persistent enable and a one-shot request. Software writes both through a small register port. The one-shot request fires once and then clears itself.

While the persistent enable is off, the block watches opcode fetches for the two-byte return-from-interrupt opcode: EDh at some address A, followed by 4Dh at A+1. Some external peripherals decode that opcode only when it is fetched under the strobe. When the block sees the pair fetched without the strobe, it holds the sequencer off for two idle states. It then refetches A and A+1 with `m1_n` low. The replayed bytes are not handed back to the sequencer, because it already holds them.

Top module: `m1_fetch_ctrl`

States: `ST_IDLE` (ready for a request), `ST_T1`/`ST_T2`/`ST_T3` (a sequencer-requested machine cycle), `ST_GAP1`/`ST_GAP2` (idle states before a replay), `ST_RT1`/`ST_RT2`/`ST_RT3` (a replayed fetch, run twice).

Transitions:
- `ST_IDLE`→`ST_T1` when a request is accepted.
- `ST_T1`→`ST_T2`→`ST_T3`, one state per clock.
- `ST_T3`→`ST_GAP1` when the return opcode is detected. Otherwise `ST_T3`→`ST_IDLE`.
- `ST_GAP1`→`ST_GAP2`→`ST_RT1`→`ST_RT2`→`ST_RT3`, one state per clock.
- `ST_RT3`→`ST_RT1` after the first replayed byte. `ST_RT3`→`ST_IDLE` after the second.

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0, `replaying`=0, `mreq_n`=`rd_n`=`m1_n`=1, and `reg_rdata`=2'b11.
- R2: A request accepted in `ST_IDLE` runs T1, T2 and T3 on the next three clocks. `bus_addr` equals the request address in T1 and T2, and `mreq_n`/`rd_n` are low in T1 and T2. In T3 `rsp_valid`=1, `rsp_data` holds the byte sampled from `bus_din` in T2, and the strobes are high.
- R3: With the enable bit (`reg_wdata[0]`) set to 1, `m1_n` is low in T1 and T2 of every opcode fetch (`req_opcode`=1). `m1_n` is never low in a data read (`req_opcode`=0).
- R4: With the enable bit at 0 and no one-shot request pending, an opcode fetch leaves `m1_n` high.
- R5: `reg_rdata[1]` always reads 1. `reg_rdata[0]` reads the enable bit.
- R6: Writing 0 to `reg_wdata[1]` arms a one-shot request. The next opcode fetch then drives `m1_n` low whatever the enable bit holds, and the fetch after it does not. Writing 1 to `reg_wdata[1]` arms nothing.
- R7: A data read leaves a pending one-shot request armed.
- R8: With the enable bit at 0, an EDh opcode fetch at A followed by a 4Dh opcode fetch at A+1, both without `m1_n`, triggers a replay after the 4Dh T3. The replay is two idle states with strobes high and `req_ready`=0, then fetches of A and A+1 with `m1_n`, `mreq_n` and `rd_n` low in RT1 and RT2 and `rsp_valid`=0. After that, `req_ready` returns to 1.
- R9: When the return opcode is fetched with `m1_n` low, no replay follows.
- R10: No replay follows if the fetch after EDh is not 4Dh, or if the 4Dh fetch is not at the address after the EDh fetch.
- R11: A one-shot request armed during the 4Dh fetch is consumed by the replay. The next opcode fetch then has `m1_n` high.
- R12: Reset sets the enable bit, drops a pending one-shot request and abandons a replay in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sequencer requests a bus read |
| req_opcode | input | 1 | 1 = opcode fetch, 0 = data read |
| req_addr | input | AW | Address of the request |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | Read data valid (T3 of a requested cycle) |
| rsp_data | output | DW | Byte read |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | bit0 persistent enable, bit1 one-shot (write 0 to arm) |
| reg_rdata | output | 2 | {1, enable} |
| bus_addr | output | AW | Bus address |
| bus_din | input | DW | Bus read data |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| m1_n | output | 1 | Opcode-fetch strobe, active low |
| replaying | output | 1 | Replay of the return opcode in progress |

## Verification
The bench builds the block with an 8-bit address and 8-bit data. A 256-byte model can then answer every address the block drives, and the return opcode can be placed at chosen addresses. That makes the adjacent-address pair, the non-adjacent pair and a prefix followed by a different byte all reachable with short directed programs. The register-port write is also timed into the T1 state of the 4Dh fetch, so the path where a replay consumes the one-shot request is exercised.

// File: rtl/m1fetch_pkg.sv
package m1fetch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_GAP1,
        ST_GAP2,
        ST_RT1,
        ST_RT2,
        ST_RT3
    } fetch_state_t;

endpackage

// File: rtl/m1_mode_reg.sv
module m1_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wdata,
    input  logic       consume,
    output logic       m1_en,
    output logic       pend,
    output logic [1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_en <= 1'b1;
            pend  <= 1'b0;
        end else begin
            if (consume)
                pend <= 1'b0;
            if (wr) begin
                m1_en <= wdata[0];
                if (!wdata[1])
                    pend <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = {1'b1, m1_en};
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !consume) |=> pend);

endmodule

// File: rtl/reti_watch.sv
module reti_watch #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] PFX = 8'hED,
    parameter logic [DW-1:0] SFX = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fin,
    input  logic          cyc_m1,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit,
    output logic [AW-1:0] base_addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic          armed;
    logic [AW-1:0] pfx_addr;

    always_comb begin
        hit       = fin && !cyc_m1 && armed && (data == SFX) && (addr == pfx_addr + ONE);
        base_addr = pfx_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            pfx_addr <= '0;
        end else if (fin) begin
            if (!cyc_m1 && data == PFX) begin
                armed    <= 1'b1;
                pfx_addr <= addr;
            end else begin
                armed    <= 1'b0;
            end
        end
    end

    // R8
    one_replay_per_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !armed);

endmodule

// File: rtl/m1_fetch_ctrl.sv
module m1_fetch_ctrl #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] PFX = 8'hED,
    parameter logic [DW-1:0] SFX = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_opcode,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    input  logic          reg_wr,
    input  logic [1:0]    reg_wdata,
    output logic [1:0]    reg_rdata,
    output logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din,
    output logic          mreq_n,
    output logic          rd_n,
    output logic          m1_n,
    output logic          replaying
);
    import m1fetch_pkg::*;

    fetch_state_t  state, nxt;
    logic [AW-1:0] cur_addr;
    logic          cur_op;
    logic          cur_m1;
    logic          rp_hi;
    logic          accept;
    logic          consume;
    logic          m1_en;
    logic          pend;
    logic          hit;
    logic          fin;
    logic [AW-1:0] base_addr;
    logic          strobe;

    always_comb begin
        accept  = req_valid && (state == ST_IDLE);
        consume = (accept && req_opcode) || (state == ST_GAP2);
        fin     = (state == ST_T3) && cur_op;
    end

    m1_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .consume (consume),
        .m1_en   (m1_en),
        .pend    (pend),
        .rdata   (reg_rdata)
    );

    reti_watch #(.AW(AW), .DW(DW), .PFX(PFX), .SFX(SFX)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (fin),
        .cyc_m1    (cur_m1),
        .addr      (cur_addr),
        .data      (rsp_data),
        .hit       (hit),
        .base_addr (base_addr)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = hit ? ST_GAP1 : ST_IDLE;
            ST_GAP1: nxt = ST_GAP2;
            ST_GAP2: nxt = ST_RT1;
            ST_RT1:  nxt = ST_RT2;
            ST_RT2:  nxt = ST_RT3;
            ST_RT3:  nxt = rp_hi ? ST_IDLE : ST_RT1;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            cur_op   <= 1'b0;
            cur_m1   <= 1'b0;
            rp_hi    <= 1'b0;
            rsp_data <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                cur_addr <= req_addr;
                cur_op   <= req_opcode;
                cur_m1   <= req_opcode && (m1_en || pend);
            end
            if (state == ST_T2)
                rsp_data <= bus_din;
            if (state == ST_GAP2)
                rp_hi <= 1'b0;
            if (state == ST_RT3)
                rp_hi <= 1'b1;
        end
    end

    always_comb begin
        strobe    = (state == ST_T1) || (state == ST_T2) ||
                    (state == ST_RT1) || (state == ST_RT2);
        mreq_n    = !strobe;
        rd_n      = !strobe;
        m1_n      = !((((state == ST_T1) || (state == ST_T2)) && cur_m1) ||
                      (state == ST_RT1) || (state == ST_RT2));
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_T3);
        replaying = (state == ST_GAP1) || (state == ST_GAP2) || (state == ST_RT1) ||
                    (state == ST_RT2) || (state == ST_RT3);
        if ((state == ST_RT1) || (state == ST_RT2) || (state == ST_RT3))
            bus_addr = base_addr + {{(AW-1){1'b0}}, rp_hi};
        else
            bus_addr = cur_addr;
    end

    // R3
    m1_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n |-> (!mreq_n && !rd_n));

    // R6
    oneshot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_opcode && pend) |=> !m1_n);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1) |=> $stable(bus_addr));

    // R8
    replay_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(replaying) |-> (mreq_n && m1_n && !req_ready));

    // R8
    replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP2) |=> (!m1_n && bus_addr == base_addr));

endmodule

// File: tb/sim_m1_fetch_ctrl.sv
module sim_m1_fetch_ctrl;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_opcode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_wdata = 2'b11;
    logic [1:0]    reg_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_din;
    logic          mreq_n;
    logic          rd_n;
    logic          m1_n;
    logic          replaying;

    logic [DW-1:0] mem [0:255];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    always_comb bus_din = mem[bus_addr];

    m1_fetch_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_addr(bus_addr), .bus_din(bus_din),
        .mreq_n(mreq_n), .rd_n(rd_n), .m1_n(m1_n), .replaying(replaying)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_fetch(input logic [7:0] a, input bit op, input bit exp_m1,
                            input bit arm, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_opcode = op;
        @(negedge clk);
        req_valid = 1'b0;
        if (arm) begin reg_wr = 1'b1; reg_wdata = 2'b00; end
        chk(mreq_n == 1'b0 && rd_n == 1'b0, {tag, " R2 T1 strobes"}, {mreq_n, rd_n}, 0);
        chk(bus_addr == a, {tag, " R2 T1 addr"}, bus_addr, a);
        chk(m1_n == !exp_m1, {tag, " T1 m1_n"}, m1_n, !exp_m1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(m1_n == !exp_m1 && mreq_n == 1'b0, {tag, " T2 m1_n"}, m1_n, !exp_m1);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_data == mem[a], {tag, " R2 T3 data"}, rsp_data, mem[a]);
        chk(mreq_n == 1'b1 && m1_n == 1'b1, {tag, " R2 T3 strobes"}, {mreq_n, m1_n}, 3);
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        chk(req_ready == 1'b1 && replaying == 1'b0, {tag, " idle after fetch"},
            {req_ready, replaying}, 2);
    endtask

    task automatic expect_replay(input logic [7:0] a, input string tag);
        for (int g = 0; g < 2; g++) begin
            @(negedge clk);
            chk(req_ready == 1'b0 && replaying == 1'b1 && mreq_n && m1_n && rd_n,
                {tag, " R8 gap"}, {req_ready, replaying, mreq_n, m1_n}, 7);
        end
        for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                chk(bus_addr == a + 8'(k), {tag, " R8 replay addr"}, bus_addr, a + 8'(k));
                chk(!m1_n && !mreq_n && !rd_n && !rsp_valid, {tag, " R8 replay strobes"},
                    {m1_n, mreq_n, rd_n, rsp_valid}, 0);
            end
            @(negedge clk);
            chk(mreq_n && m1_n && !rsp_valid, {tag, " R8 replay T3"},
                {mreq_n, m1_n, rsp_valid}, 6);
        end
        @(negedge clk);
        chk(req_ready == 1'b1 && replaying == 1'b0, {tag, " R8 replay end"}, req_ready, 1);
    endtask

    task automatic t_reset;
        chk(req_ready && !rsp_valid && !replaying, "R1 ready", {req_ready, rsp_valid}, 2);
        chk(mreq_n && rd_n && m1_n, "R1 strobes", {mreq_n, rd_n, m1_n}, 7);
        chk(reg_rdata == 2'b11, "R1 R5 rdata", reg_rdata, 3);
    endtask

    task automatic t_enabled;
        do_fetch(8'h05, 1'b1, 1'b1, 1'b0, "R3 opcode"); expect_idle("R3");
        do_fetch(8'h06, 1'b0, 1'b0, 1'b0, "R3 data read"); expect_idle("R3");
        do_fetch(8'h10, 1'b1, 1'b1, 1'b0, "R9 prefix");   expect_idle("R9");
        do_fetch(8'h11, 1'b1, 1'b1, 1'b0, "R9 suffix");   expect_idle("R9 no replay");
    endtask

    task automatic t_disabled;
        wr_reg(2'b10);
        chk(reg_rdata == 2'b10, "R5 rdata enable off", reg_rdata, 2);
        do_fetch(8'h07, 1'b1, 1'b0, 1'b0, "R4 no m1"); expect_idle("R4");
    endtask

    task automatic t_oneshot;
        wr_reg(2'b00);
        chk(reg_rdata == 2'b10, "R5 bit1 reads 1", reg_rdata, 2);
        do_fetch(8'h08, 1'b0, 1'b0, 1'b0, "R7 data read"); expect_idle("R7");
        do_fetch(8'h09, 1'b1, 1'b1, 1'b0, "R6 R7 oneshot"); expect_idle("R6");
        do_fetch(8'h0A, 1'b1, 1'b0, 1'b0, "R6 self clear"); expect_idle("R6");
        wr_reg(2'b10);
        do_fetch(8'h0B, 1'b1, 1'b0, 1'b0, "R6 write 1 no arm"); expect_idle("R6");
    endtask

    task automatic t_replay;
        do_fetch(8'h10, 1'b1, 1'b0, 1'b0, "R8 prefix"); expect_idle("R8");
        do_fetch(8'h11, 1'b1, 1'b0, 1'b0, "R8 suffix");
        expect_replay(8'h10, "R8");
    endtask

    task automatic t_nonadj;
        do_fetch(8'h20, 1'b1, 1'b0, 1'b0, "R10 prefix");   expect_idle("R10");
        do_fetch(8'h21, 1'b1, 1'b0, 1'b0, "R10 other");    expect_idle("R10 other byte");
        do_fetch(8'h20, 1'b1, 1'b0, 1'b0, "R10 prefix b"); expect_idle("R10");
        do_fetch(8'h30, 1'b1, 1'b0, 1'b0, "R10 far sfx");  expect_idle("R10 far address");
    endtask

    task automatic t_oneshot_replay;
        do_fetch(8'h10, 1'b1, 1'b0, 1'b0, "R11 prefix"); expect_idle("R11");
        do_fetch(8'h11, 1'b1, 1'b0, 1'b1, "R11 suffix armed");
        expect_replay(8'h10, "R11");
        do_fetch(8'h12, 1'b1, 1'b0, 1'b0, "R11 consumed"); expect_idle("R11");
    endtask

    task automatic t_reset_clear;
        wr_reg(2'b00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(reg_rdata == 2'b11, "R12 enable restored", reg_rdata, 3);
        wr_reg(2'b10);
        do_fetch(8'h13, 1'b1, 1'b0, 1'b0, "R12 oneshot dropped"); expect_idle("R12");
        do_fetch(8'h10, 1'b1, 1'b0, 1'b0, "R12 prefix"); expect_idle("R12");
        do_fetch(8'h11, 1'b1, 1'b0, 1'b0, "R12 suffix");
        @(negedge clk);
        chk(replaying == 1'b1, "R12 replay started", replaying, 1);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(req_ready && !replaying && mreq_n && m1_n, "R12 replay abandoned",
            {req_ready, replaying, mreq_n, m1_n}, 11);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        mem[8'h10] = 8'hED; mem[8'h11] = 8'h4D;
        mem[8'h20] = 8'hED; mem[8'h21] = 8'h00;
        mem[8'h30] = 8'h4D;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enabled();
        t_disabled();
        t_oneshot();
        t_replay();
        t_nonadj();
        t_oneshot_replay();
        t_reset_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule